// File: doc/BRIEF.md
# Multi-Packet Transmit FIFO with Ready Flow Control

This block is a single-clock transmit FIFO between a packet write bus and a serial-side consumer. The writer presents words marked with start-of-packet and end-of-packet flags, grouped into bursts that close with a burst-end flag. The block stores the words and drives a registered transmit-ready output. The bus master uses it to decide whether it may begin another burst. The consumer sees only words of packets whose end marker has been written, so it always drains whole packets in the order they arrived.

A two-bit mode input picks between holding many packets and the legacy one-packet behaviour. In many-packet mode, ready falls for any of three reasons: too little free space against a programmable threshold, sixteen complete packets held, or a burst still open on the write bus. Packets shorter than the minimum length in that mode are discarded and reported by a one-cycle error pulse. They are never stored.

Top module: `mpkt_txfifo`

## Requirements
- R1: `mode_sel` equal to 1 selects many-packet mode. The values 0, 2 and 3 all select single-packet mode, in which a packet of any length is stored.
- R2: In many-packet mode the FIFO holds up to MAX_PKTS (16) complete packets at once.
- R3: `tx_ready` is low whenever free word space (DEPTH minus stored words) is below `tx_thresh`.
- R4: In many-packet mode, `tx_ready` is low while the complete-packet count equals MAX_PKTS.
- R5: In many-packet mode, `tx_ready` is low after a written word that lacks `wr_burst_end`, and stays low until a word with `wr_burst_end` is written.
- R6: In many-packet mode, a packet whose length is under MIN_BYTES (32 bytes = 8 words of 4 bytes) is discarded. `short_err` is high for exactly the one cycle after its end word.
- R7: The packet count rises by one when an end word is accepted and stored. It falls by one when the consumer takes a word with `rd_eop` set. When both happen in the same cycle, it is unchanged.
- R8: In single-packet mode, `tx_ready` is high only when the threshold check passes, no complete packet is held and no packet is partly written.
- R9: A write while DEPTH words are stored is ignored.
- R10: `rd_valid` is high only for words of packets whose end word has been stored. Words leave in write order, with `rd_eop` marking each packet's last word.
- R11: `tx_ready` is a register. It is low in reset and after each edge reflects the state reached at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | 1 = many-packet mode, other values single-packet mode |
| tx_thresh | input | AW+1 | Minimum free words needed for ready |
| wr_valid | input | 1 | Write word valid |
| wr_data | input | DW | Write word |
| wr_sop | input | 1 | First word of a packet |
| wr_eop | input | 1 | Last word of a packet |
| wr_burst_end | input | 1 | Last word of the current burst |
| tx_ready | output | 1 | Master may start a new burst |
| short_err | output | 1 | Pulse: short packet discarded |
| rd_ready | input | 1 | Consumer takes the presented word |
| rd_valid | output | 1 | A stored word is presented |
| rd_data | output | DW | Presented word |
| rd_eop | output | 1 | Presented word ends its packet |

## Verification
The assertions take for granted that the master starts a burst only when `tx_ready` is high, so the packet count never passes MAX_PKTS. They also assume every packet opens with a start word and ends with an end word, and that a burst-end arrives on the packet's last word. The stimulus keeps to these rules by waiting for ready before each packet, writing one packet per burst, and changing mode only while the FIFO is empty. The one deliberate exception is the overflow case. There, in single-packet mode with the threshold at zero, words are forced into a full FIFO without regard to ready.

// File: rtl/mpf_pkg.sv
package mpf_pkg;
  localparam logic [1:0] MODE_MULTI = 2'd1;

  function automatic logic is_multi(input logic [1:0] m);
    return m == MODE_MULTI;
  endfunction
endpackage

// File: rtl/mpf_store.sv
module mpf_store #(
  parameter int EW = 33,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [EW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [EW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [EW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/mpf_wr_track.sv
module mpf_wr_track #(
  parameter int AW        = 8,
  parameter int MIN_WORDS = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          multi,
  input  logic          wr_valid,
  input  logic          wr_sop,
  input  logic          wr_eop,
  input  logic          wr_burst_end,
  input  logic          full,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wr_ptr_q,
  output logic [AW:0]   wr_ptr_d,
  output logic [AW:0]   commit_q,
  output logic          burst_d,
  output logic          open_d,
  output logic          pkt_inc,
  output logic          short_err
);
  localparam int LW = AW + 2;

  logic [AW:0]   start_q, start_d, commit_d;
  logic [LW-1:0] wcnt_q, wcnt_d, len;
  logic          burst_q, open_q, accept, drop;

  always_comb begin
    accept   = wr_valid && !full;
    len      = wr_sop ? LW'(1) : wcnt_q + LW'(1);
    drop     = accept && wr_eop && multi && (len < LW'(MIN_WORDS));
    wr_ptr_d = wr_ptr_q;
    commit_d = commit_q;
    start_d  = start_q;
    wcnt_d   = wcnt_q;
    open_d   = open_q;
    if (accept) begin
      wcnt_d = len;
      if (wr_sop) start_d = wr_ptr_q;
      if (drop) begin
        wr_ptr_d = wr_sop ? wr_ptr_q : start_q;
      end else begin
        wr_ptr_d = wr_ptr_q + 1'b1;
        if (wr_eop) commit_d = wr_ptr_q + 1'b1;
      end
      if (wr_eop)      open_d = 1'b0;
      else if (wr_sop) open_d = 1'b1;
    end
    burst_d = wr_valid ? !wr_burst_end : burst_q;
    pkt_inc = accept && wr_eop && !drop;
  end

  assign we    = accept;
  assign waddr = wr_ptr_q[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q  <= '0;
      commit_q  <= '0;
      start_q   <= '0;
      wcnt_q    <= '0;
      open_q    <= 1'b0;
      burst_q   <= 1'b0;
      short_err <= 1'b0;
    end else begin
      wr_ptr_q  <= wr_ptr_d;
      commit_q  <= commit_d;
      start_q   <= start_d;
      wcnt_q    <= wcnt_d;
      open_q    <= open_d;
      burst_q   <= burst_d;
      short_err <= drop;
    end
  end
endmodule

// File: rtl/mpf_rd_track.sv
module mpf_rd_track #(
  parameter int AW    = 8,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_ready,
  input  logic [AW:0]      commit_q,
  input  logic             eop_bit,
  input  logic             pkt_inc,
  output logic             rd_valid,
  output logic [AW-1:0]    raddr,
  output logic [AW:0]      rd_ptr_q,
  output logic [AW:0]      rd_ptr_d,
  output logic [CNT_W-1:0] pkt_cnt_q,
  output logic [CNT_W-1:0] pkt_cnt_d
);
  logic fire, pkt_dec;

  always_comb begin
    rd_valid  = rd_ptr_q != commit_q;
    fire      = rd_valid && rd_ready;
    pkt_dec   = fire && eop_bit;
    rd_ptr_d  = rd_ptr_q + {{AW{1'b0}}, fire};
    pkt_cnt_d = pkt_cnt_q;
    if (pkt_inc && !pkt_dec)      pkt_cnt_d = pkt_cnt_q + 1'b1;
    else if (pkt_dec && !pkt_inc) pkt_cnt_d = pkt_cnt_q - 1'b1;
  end

  assign raddr = rd_ptr_q[AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ptr_q  <= '0;
      pkt_cnt_q <= '0;
    end else begin
      rd_ptr_q  <= rd_ptr_d;
      pkt_cnt_q <= pkt_cnt_d;
    end
  end
endmodule

// File: rtl/mpkt_txfifo.sv
module mpkt_txfifo #(
  parameter int DW        = 32,
  parameter int AW        = 8,
  parameter int MAX_PKTS  = 16,
  parameter int MIN_BYTES = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode_sel,
  input  logic [AW:0]   tx_thresh,
  input  logic          wr_valid,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_sop,
  input  logic          wr_eop,
  input  logic          wr_burst_end,
  output logic          tx_ready,
  output logic          short_err,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          rd_eop
);
  import mpf_pkg::*;

  localparam int DEPTH     = 1 << AW;
  localparam int BPW       = DW / 8;
  localparam int MIN_WORDS = (MIN_BYTES + BPW - 1) / BPW;
  localparam int CNT_W     = $clog2(MAX_PKTS + 1) + 1;
  localparam int EW        = DW + 1;

  logic              multi, full, we, burst_d, open_d, pkt_inc, below, ready_d;
  logic [AW-1:0]     waddr, raddr;
  logic [AW:0]       wr_ptr_q, wr_ptr_d, commit_q, rd_ptr_q, rd_ptr_d;
  logic [AW:0]       occ_words, occ_d, free_words, free_d;
  logic [CNT_W-1:0]  pkt_cnt, pkt_cnt_d;
  logic [EW-1:0]     rword;

  assign multi      = is_multi(mode_sel);
  assign occ_words  = wr_ptr_q - rd_ptr_q;
  assign free_words = (AW+1)'(DEPTH) - occ_words;
  assign full       = occ_words == (AW+1)'(DEPTH);

  mpf_store #(.EW(EW), .AW(AW)) store_i (
    .clk(clk), .we(we), .waddr(waddr), .wdata({wr_eop, wr_data}),
    .raddr(raddr), .rdata(rword)
  );

  mpf_wr_track #(.AW(AW), .MIN_WORDS(MIN_WORDS)) wr_i (
    .clk(clk), .rst(rst), .multi(multi), .wr_valid(wr_valid),
    .wr_sop(wr_sop), .wr_eop(wr_eop), .wr_burst_end(wr_burst_end),
    .full(full), .we(we), .waddr(waddr), .wr_ptr_q(wr_ptr_q),
    .wr_ptr_d(wr_ptr_d), .commit_q(commit_q), .burst_d(burst_d),
    .open_d(open_d), .pkt_inc(pkt_inc), .short_err(short_err)
  );

  mpf_rd_track #(.AW(AW), .CNT_W(CNT_W)) rd_i (
    .clk(clk), .rst(rst), .rd_ready(rd_ready), .commit_q(commit_q),
    .eop_bit(rword[DW]), .pkt_inc(pkt_inc), .rd_valid(rd_valid),
    .raddr(raddr), .rd_ptr_q(rd_ptr_q), .rd_ptr_d(rd_ptr_d),
    .pkt_cnt_q(pkt_cnt), .pkt_cnt_d(pkt_cnt_d)
  );

  assign rd_data = rword[DW-1:0];
  assign rd_eop  = rword[DW];

  always_comb begin
    occ_d  = wr_ptr_d - rd_ptr_d;
    free_d = (AW+1)'(DEPTH) - occ_d;
    below  = free_d < tx_thresh;
    if (multi)
      ready_d = !below && (pkt_cnt_d != CNT_W'(MAX_PKTS)) && !burst_d;
    else
      ready_d = !below && (pkt_cnt_d == '0) && !open_d;
  end

  always_ff @(posedge clk) begin
    if (rst) tx_ready <= 1'b0;
    else     tx_ready <= ready_d;
  end
endmodule

// File: rtl/mpf_checker.sv
module mpf_checker #(
  parameter int AW       = 8,
  parameter int CNT_W    = 6,
  parameter int MAX_PKTS = 16
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       mode_sel,
  input logic [AW:0]      tx_thresh,
  input logic             wr_valid,
  input logic             wr_eop,
  input logic             wr_burst_end,
  input logic             tx_ready,
  input logic             short_err,
  input logic [CNT_W-1:0] pkt_cnt,
  input logic [AW:0]      occ_words,
  input logic [AW:0]      free_words
);
  localparam int DEPTH = 1 << AW;

  AST_THRESH_GATE: assert property (@(posedge clk) disable iff (rst)
    tx_ready |-> free_words >= $past(tx_thresh)); // R3
  AST_PKT_CAP: assert property (@(posedge clk) disable iff (rst)
    pkt_cnt <= CNT_W'(MAX_PKTS)); // R2
  AST_BURST_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'd1 && wr_valid && !wr_burst_end) |=> !tx_ready); // R5
  AST_SHORT_CAUSE: assert property (@(posedge clk) disable iff (rst)
    short_err |-> $past(wr_valid && wr_eop && mode_sel == 2'd1)); // R6
  AST_PKT_STEP: assert property (@(posedge clk) disable iff (rst)
    (pkt_cnt == $past(pkt_cnt)) || (pkt_cnt == $past(pkt_cnt) + 1'b1)
    || (pkt_cnt == $past(pkt_cnt) - 1'b1)); // R7
  AST_SINGLE_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (tx_ready && $past(mode_sel) != 2'd1) |-> pkt_cnt == '0); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    occ_words <= (AW+1)'(DEPTH)); // R9
endmodule

bind mpkt_txfifo mpf_checker #(.AW(AW), .CNT_W(CNT_W), .MAX_PKTS(MAX_PKTS)) chk_i (
  .clk(clk), .rst(rst), .mode_sel(mode_sel), .tx_thresh(tx_thresh),
  .wr_valid(wr_valid), .wr_eop(wr_eop), .wr_burst_end(wr_burst_end),
  .tx_ready(tx_ready), .short_err(short_err), .pkt_cnt(pkt_cnt),
  .occ_words(occ_words), .free_words(free_words)
);

// File: tb/mpkt_txfifo_tb.sv
module mpkt_txfifo_tb_top;
  localparam int DW = 32, AW = 8, DEPTH = 256, MAXP = 16, MINW = 8;

  logic          clk = 1'b0, rst = 1'b1;
  logic [1:0]    mode_sel = 2'd1;
  logic [AW:0]   tx_thresh = 9'd16;
  logic          wr_valid = 1'b0, wr_sop = 1'b0, wr_eop = 1'b0, wr_burst_end = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          tx_ready, short_err, rd_ready, rd_valid, rd_eop;
  logic [DW-1:0] rd_data;
  logic          rd_rand = 1'b0, rd_force = 1'b0, rnd_bit = 1'b0;

  int n_vec = 0, n_fail = 0, cyc = 0, rd_words = 0, rd_eops = 0;
  logic [DW-1:0] seq = 32'h100;

  logic [DW:0] cq[$];
  logic [DW:0] pq[$];
  int   m_pkt = 0;
  logic m_burst = 0, m_open = 0, m_ready = 0, m_short = 0;

  always #4 clk = ~clk;
  assign rd_ready = rd_rand ? rnd_bit : rd_force;
  always @(negedge clk) rnd_bit <= 1'($urandom % 2);

  mpkt_txfifo dut_i (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .tx_thresh(tx_thresh),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_sop(wr_sop), .wr_eop(wr_eop),
    .wr_burst_end(wr_burst_end), .tx_ready(tx_ready), .short_err(short_err),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .rd_data(rd_data), .rd_eop(rd_eop)
  );

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    cyc++;
    if (rd_valid && rd_ready) begin
      rd_words++;
      if (rd_eop) rd_eops++;
    end
    if (rst) begin
      cq.delete(); pq.delete();
      m_pkt = 0; m_burst = 0; m_open = 0; m_ready = 0; m_short = 0;
    end else begin
      automatic bit full = (cq.size() + pq.size()) >= DEPTH;
      automatic bit multi = (mode_sel == 2'd1);
      automatic int freew;
      if (rd_ready && cq.size() > 0) begin
        automatic logic [DW:0] w = cq.pop_front();
        if (w[DW]) m_pkt--;
      end
      m_short = 0;
      if (wr_valid && !full) begin
        pq.push_back({wr_eop, wr_data});
        if (wr_eop) begin
          if (multi && pq.size() < MINW) begin
            pq.delete(); m_short = 1;
          end else begin
            foreach (pq[i]) cq.push_back(pq[i]);
            pq.delete(); m_pkt++;
          end
          m_open = 0;
        end else if (wr_sop) m_open = 1;
      end
      if (wr_valid) m_burst = !wr_burst_end;
      freew = DEPTH - (cq.size() + pq.size());
      m_ready = (freew >= int'(tx_thresh)) &&
                (multi ? (m_pkt != MAXP && !m_burst) : (m_pkt == 0 && !m_open));
    end
  end

  // compare against the model away from the active edge
  always @(negedge clk) begin
    n_vec++;
    if (tx_ready !== m_ready) begin
      n_fail++;
      $display("FAIL R3 R4 R5 R8 R11 tx_ready actual %0b expected %0b", tx_ready, m_ready);
    end
    n_vec++;
    if (short_err !== m_short) begin
      n_fail++;
      $display("FAIL R6 short_err actual %0b expected %0b", short_err, m_short);
    end
    n_vec++;
    if (rd_valid !== (cq.size() > 0)) begin
      n_fail++;
      $display("FAIL R10 rd_valid actual %0b expected %0b", rd_valid, cq.size() > 0);
    end else if (rd_valid && {rd_eop, rd_data} !== cq[0]) begin
      n_fail++;
      $display("FAIL R10 word actual %h expected %h", {rd_eop, rd_data}, cq[0]);
    end
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual cycle %0d expected under 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic send(input int len, input bit wait_rdy);
    if (wait_rdy) while (!tx_ready) @(negedge clk);
    for (int i = 0; i < len; i++) begin
      if (i == 1 && wait_rdy && mode_sel == 2'd1)
        check(tx_ready == 1'b0, "R5 ready during burst", tx_ready, 0);
      wr_valid = 1'b1; wr_sop = (i == 0); wr_eop = (i == len - 1);
      wr_burst_end = (i == len - 1); wr_data = seq; seq++;
      @(negedge clk);
    end
    wr_valid = 1'b0; wr_sop = 1'b0; wr_eop = 1'b0; wr_burst_end = 1'b0;
  endtask

  task automatic drain();
    rd_rand = 1'b0; rd_force = 1'b1;
    @(negedge clk);
    while (rd_valid) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int base_w, base_e;
    repeat (3) @(negedge clk);
    check(tx_ready == 0 && rd_valid == 0 && short_err == 0, "R11 reset state", tx_ready, 0);
    rst = 1'b0;
    @(negedge clk);
    check(tx_ready == 1, "R11 R3 ready after reset", tx_ready, 1);

    // random traffic in many-packet mode with a random consumer
    rd_rand = 1'b1;
    for (int p = 0; p < 20; p++) send(8 + int'($urandom % 13), 1);
    drain();

    // packet cap
    rd_force = 1'b0;
    for (int p = 0; p < MAXP; p++) send(MINW, 1);
    @(negedge clk);
    check(tx_ready == 0, "R4 R2 ready at sixteen packets", tx_ready, 0);
    base_e = rd_eops; rd_force = 1'b1;
    while (rd_eops == base_e) @(negedge clk);
    rd_force = 1'b0;
    @(negedge clk);
    check(tx_ready == 1, "R7 ready after one packet read", tx_ready, 1);
    drain();

    // threshold
    tx_thresh = 9'd200; rd_force = 1'b0;
    @(negedge clk);
    for (int p = 0; p < 8; p++) send(MINW, 0);
    @(negedge clk);
    check(tx_ready == 0, "R3 ready with free 192 under 200", tx_ready, 0);
    drain();
    tx_thresh = 9'd16;
    @(negedge clk);

    // short packets
    send(5, 1);
    check(short_err == 1, "R6 error pulse after 5-word packet", short_err, 1);
    @(negedge clk);
    check(short_err == 0 && rd_valid == 0, "R6 pulse ends, nothing stored", rd_valid, 0);
    send(1, 1);
    check(short_err == 1, "R6 error pulse after 1-word packet", short_err, 1);
    repeat (2) @(negedge clk);

    // single-packet modes
    rd_force = 1'b0; mode_sel = 2'd0;
    @(negedge clk);
    send(5, 1);
    check(tx_ready == 0, "R8 ready low with one packet held", tx_ready, 0);
    check(rd_valid == 1 && short_err == 0, "R1 short packet kept in mode 0", rd_valid, 1);
    drain();
    check(tx_ready == 1, "R8 ready back when empty", tx_ready, 1);
    mode_sel = 2'd2; rd_force = 1'b0;
    @(negedge clk);
    send(12, 1);
    check(tx_ready == 0, "R1 R8 mode 2 holds one packet", tx_ready, 0);
    drain();
    mode_sel = 2'd3; rd_rand = 1'b1;
    @(negedge clk);
    for (int p = 0; p < 6; p++) send(2 + int'($urandom % 10), 1);
    drain();

    // overflow: fill exactly, then force another packet
    mode_sel = 2'd0; tx_thresh = 9'd0; rd_force = 1'b0;
    @(negedge clk);
    send(DEPTH, 0);
    send(4, 0);
    check(tx_ready == 0, "R9 ready with full FIFO", tx_ready, 0);
    base_w = rd_words; base_e = rd_eops;
    drain();
    check(rd_words - base_w == DEPTH, "R9 words read after overflow", rd_words - base_w, DEPTH);
    check(rd_eops - base_e == 1, "R9 packets read after overflow", rd_eops - base_e, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule